// File: doc/BRIEF.md
# Configuration Image Address Patcher

This block takes a fixed-size configuration image of 768 bytes on a byte-wide input stream and sends it out again on a byte-wide output stream. If patching is enabled, it writes a supplied 48-bit hardware address into a six-byte field of the image. It also recomputes the 16-bit integrity word that the image carries near its start.

The integrity word sits ahead of most of the data it covers. For that reason the block first takes in the whole image and stores it. Next, it spends one cycle finishing the checksum. Only then does it send the image out, putting the new checksum into its slot as that slot goes by.

The patch-enable flag and the address are sampled together with byte 0 of each image. The computed checksum is also available on a separate status output, with a one-cycle pulse marking it valid.

The control is a three-state machine:
- **ST_FILL** accepts bytes. It moves to **ST_SEAL** once byte 767 has been accepted.
- **ST_SEAL** lasts one cycle and pulses the checksum status. It always moves on to **ST_DRAIN**.
- **ST_DRAIN** presents bytes. It returns to **ST_FILL** when byte 767 is handshaken on the output.

Reset enters ST_FILL.

Top module: `cfgp_patcher`

## Requirements
- R1: An image is exactly 768 bytes. `in_ready` is high in the fill phase until byte 767 is accepted, then stays low until output byte 767 has been handshaken. No input is taken while the image is being emitted.
- R2: `out_last` is high only while output byte 767 is presented.
- R3: With patching enabled, output bytes 10 to 15 carry the 48-bit address, most significant octet first (byte 10 = bits 47:40, byte 15 = bits 7:0).
- R4: With patching enabled, output byte 4 carries bits 7:0 of the computed checksum and output byte 5 carries bits 15:8.
- R5: The checksum is the bitwise inverse of the XOR of all 384 little-endian 16-bit words of the image. In each word the even-offset byte is the low half and the odd-offset byte is the high half. Bytes 4 and 5 count as zero, and the substituted address bytes are used when patching is enabled.
- R6: With patching disabled, every output byte equals the corresponding input byte. The checksum is still computed, by the R5 rule, over the unmodified bytes.
- R7: `sum_valid` is a single-cycle pulse in the cycle after byte 767 is accepted, before the first output byte is presented. `sum_value` holds the checksum during the pulse and throughout emission.
- R8: `patch_en` and `hw_addr` are sampled when byte 0 is accepted. Changes to them later in the same image have no effect.
- R9: Output bytes leave in input order. While `out_valid` is high and `out_ready` low, `out_data` and `out_last` hold steady.
- R10: After reset, `in_ready` is high and `out_valid` and `sum_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 8 | Input image byte |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Block can accept an input byte |
| patch_en | input | 1 | Substitute address and checksum in this image |
| hw_addr | input | 48 | Address to substitute, MSB octet first |
| out_data | output | 8 | Output image byte |
| out_valid | output | 1 | Output byte presented |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_last | output | 1 | Presented byte is byte 767 |
| sum_value | output | 16 | Computed checksum |
| sum_valid | output | 1 | One-cycle pulse: checksum final |

## Verification
A wrong byte index becomes visible at the ports within one handshake:
- A misplaced address byte or checksum byte shows up in `out_data` at the first affected offset.
- A wrong phase shows up as `in_ready` or `out_valid` disagreeing with the model in the very next cycle.

An accumulator error cannot be seen until the seal cycle. There it shows up in `sum_value`, and again at output bytes 4 and 5.

A stale patch flag or address only shows up in the next image. For that reason the bench changes both inputs in the middle of an image and then runs several images back to back.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_SEAL  = 2'd1,
        ST_DRAIN = 2'd2
    } cfgp_state_e;
endpackage

// File: rtl/cfgp_store.sv
module cfgp_store #(
    parameter int DEPTH = 768,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/cfgp_xsum.sv
module cfgp_xsum #(
    parameter int LANE = 8,
    localparam int SW  = 2 * LANE
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            en,
    input  logic            odd,
    input  logic [LANE-1:0] data,
    output logic [SW-1:0]   sum
);
    logic [SW-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (en) begin
            if (odd) begin
                acc_q[SW-1:LANE] <= acc_q[SW-1:LANE] ^ data;
            end else begin
                acc_q[LANE-1:0] <= acc_q[LANE-1:0] ^ data;
            end
        end
    end

    assign sum = ~acc_q;
endmodule

// File: rtl/cfgp_patcher.sv
module cfgp_patcher #(
    parameter int IMG_BYTES  = 768,
    parameter int SUM_OFS    = 4,
    parameter int ADDR_OFS   = 10,
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              in_data,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    patch_en,
    input  logic [8*ADDR_BYTES-1:0] hw_addr,
    output logic [7:0]              out_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic                    out_last,
    output logic [15:0]             sum_value,
    output logic                    sum_valid
);
    import cfgp_pkg::*;

    localparam int IW = $clog2(IMG_BYTES);
    localparam int AB = 8 * ADDR_BYTES;
    localparam logic [IW-1:0] LAST_IDX = IW'(IMG_BYTES - 1);
    localparam logic [IW-1:0] SUM_LO   = IW'(SUM_OFS);
    localparam logic [IW-1:0] SUM_HI   = IW'(SUM_OFS + 1);

    cfgp_state_e   state_q, state_d;
    logic [IW-1:0] idx_q;
    logic          patch_q;
    logic [AB-1:0] addr_q;

    logic          in_fire, out_fire, at_last;
    logic          live_patch;
    logic [AB-1:0] live_addr;
    logic [7:0]    wr_byte, sum_byte, rd_byte;
    logic [15:0]   sum_w;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;
    assign at_last  = (idx_q == LAST_IDX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL:  if (in_fire && at_last) state_d = ST_SEAL;
            ST_SEAL:  state_d = ST_DRAIN;
            ST_DRAIN: if (out_fire && at_last) state_d = ST_FILL;
            default:  state_d = ST_FILL;
        endcase
    end

    // output decode
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        sum_valid = 1'b0;
        unique case (state_q)
            ST_FILL:  in_ready  = 1'b1;
            ST_SEAL:  sum_valid = 1'b1;
            ST_DRAIN: out_valid = 1'b1;
            default:  in_ready  = 1'b0;
        endcase
    end
    assign out_last = out_valid && at_last;

    // byte index and per-image capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            patch_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            if (in_fire || out_fire) begin
                idx_q <= at_last ? '0 : idx_q + 1'b1;
            end
            if (in_fire && idx_q == '0) begin
                patch_q <= patch_en;
                addr_q  <= hw_addr;
            end
        end
    end

    assign live_patch = (idx_q == '0) ? patch_en : patch_q;
    assign live_addr  = (idx_q == '0) ? hw_addr  : addr_q;

    // address substitution on the way in
    always_comb begin
        wr_byte = in_data;
        if (live_patch) begin
            for (int j = 0; j < ADDR_BYTES; j++) begin
                if (idx_q == IW'(ADDR_OFS + j)) begin
                    wr_byte = live_addr[8*(ADDR_BYTES-1-j) +: 8];
                end
            end
        end
    end

    assign sum_byte = (idx_q == SUM_LO || idx_q == SUM_HI) ? 8'h00 : wr_byte;

    cfgp_store #(.DEPTH(IMG_BYTES), .DW(8)) u_store (
        .clk     (clk),
        .wr_en   (in_fire),
        .wr_addr (idx_q),
        .wr_data (wr_byte),
        .rd_addr (idx_q),
        .rd_data (rd_byte)
    );

    cfgp_xsum #(.LANE(8)) u_xsum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (out_fire && at_last),
        .en    (in_fire),
        .odd   (idx_q[0]),
        .data  (sum_byte),
        .sum   (sum_w)
    );

    assign sum_value = sum_w;

    // checksum insertion on the way out
    always_comb begin
        out_data = rd_byte;
        if (patch_q && idx_q == SUM_LO) out_data = sum_w[7:0];
        if (patch_q && idx_q == SUM_HI) out_data = sum_w[15:8];
    end

    a_r1_no_input_while_emitting : assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    a_r1_reopen_after_last : assert property (@(posedge clk) disable iff (!rst_n)
        (out_fire && out_last) |=> in_ready);
    a_r2_last_needs_valid : assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    a_r7_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid |=> !sum_valid);
    a_r7_sum_before_data : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(sum_valid));
    a_r7_sum_held : assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> $stable(sum_value));
    a_r9_hold_under_stall : assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

// File: tb/test_cfgp_patcher.sv
module test_cfgp_patcher;
    localparam int CLK_PERIOD = 10;
    localparam int N = 768;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        patch_en = 1'b0;
    logic [47:0] hw_addr = '0;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        out_last;
    logic [15:0] sum_value;
    logic        sum_valid;

    int total = 0;
    int bad = 0;
    int rdy_mode = 0;
    int imgs_done = 0;

    logic [7:0]  img [N];
    logic [7:0]  exp_out [N];
    logic [15:0] exp_sum;

    // behavioural model state: 0 fill, 1 seal, 2 drain
    int mdl_phase = 0;
    int mdl_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgp_patcher i_cfgp_patcher (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .patch_en(patch_en), .hw_addr(hw_addr),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_last(out_last), .sum_value(sum_value), .sum_valid(sum_valid)
    );

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string byte_tag(input int i, input logic p);
        if (p && i >= 10 && i <= 15) return "R3";
        if (p && (i == 4 || i == 5)) return "R4";
        if (!p) return "R6";
        return "R9";
    endfunction

    // expected image from requirement rules
    task automatic prepare(input logic p, input logic [47:0] a);
        logic [15:0] acc;
        for (int i = 0; i < N; i++) exp_out[i] = img[i];
        if (p) for (int j = 0; j < 6; j++) exp_out[10+j] = a[8*(5-j) +: 8];
        acc = '0;
        for (int w = 0; w < N/2; w++) begin
            logic [7:0] lo, hi;
            lo = (2*w == 4) ? 8'h00 : exp_out[2*w];
            hi = (2*w+1 == 5) ? 8'h00 : exp_out[2*w+1];
            acc ^= {hi, lo};
        end
        exp_sum = ~acc;
        if (p) begin
            exp_out[4] = exp_sum[7:0];
            exp_out[5] = exp_sum[15:8];
        end
    endtask

    logic cur_patch = 1'b0;

    // model advance
    always @(posedge clk) begin
        if (!rst_n) begin
            mdl_phase = 0;
            mdl_cnt = 0;
        end else begin
            case (mdl_phase)
                0: if (in_valid) begin
                    if (mdl_cnt == N-1) begin mdl_phase = 1; mdl_cnt = 0; end
                    else mdl_cnt++;
                end
                1: mdl_phase = 2;
                default: if (out_ready) begin
                    if (mdl_cnt == N-1) begin mdl_phase = 0; mdl_cnt = 0; imgs_done++; end
                    else mdl_cnt++;
                end
            endcase
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            check(in_ready == (mdl_phase == 0), "R1 in_ready", in_ready, mdl_phase == 0);
            check(out_valid == (mdl_phase == 2), "R1 out_valid", out_valid, mdl_phase == 2);
            check(sum_valid == (mdl_phase == 1), "R7 sum_valid", sum_valid, mdl_phase == 1);
            if (mdl_phase != 0) check(sum_value == exp_sum, "R5 sum_value", sum_value, exp_sum);
            if (out_valid && mdl_phase == 2) begin
                check(out_data == exp_out[mdl_cnt], byte_tag(mdl_cnt, cur_patch), out_data, exp_out[mdl_cnt]);
                check(out_last == (mdl_cnt == N-1), "R2 out_last", out_last, mdl_cnt == N-1);
            end
        end
    end

    // output readiness
    initial forever begin
        @(negedge clk);
        out_ready = (rdy_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
    end

    // drive one image; flip: change patch inputs mid-image (R8); junk: hold in_valid during drain (R1)
    task automatic run_image(input logic p, input logic [47:0] a, input bit gaps,
                             input bit flip, input bit junk);
        int b = 0;
        int done0 = imgs_done;
        prepare(p, a);
        cur_patch = p;
        @(negedge clk);
        patch_en = p;
        hw_addr = a;
        while (b < N) begin
            if (gaps && ($urandom % 4) == 0) begin
                in_valid = 1'b0;
            end else begin
                in_valid = 1'b1;
                in_data = img[b];
                b++;
            end
            @(negedge clk);
            if (flip && b == 3) begin
                patch_en = ~p;
                hw_addr = ~a;
            end
        end
        if (junk) begin
            in_data = 8'hEE;
            repeat (50) @(negedge clk);
        end
        in_valid = 1'b0;
        while (imgs_done == done0) @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        fork
            begin
                while (cyc < 200000) begin @(posedge clk); cyc++; end
                check(1'b0, "watchdog", cyc, 200000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        join_none
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
        check(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
        check(sum_valid == 1'b0, "R10 sum_valid", sum_valid, 0);

        // patched, counting pattern, no stalls
        for (int i = 0; i < N; i++) img[i] = 8'((i * 37 + 5) & 255);
        rdy_mode = 0;
        run_image(1'b1, 48'h0A1B2C3D4E5F, 1'b0, 1'b0, 1'b0);

        // pass-through, random data, input gaps and output stalls (R6, R9)
        for (int i = 0; i < N; i++) img[i] = 8'($urandom);
        rdy_mode = 1;
        run_image(1'b0, 48'h112233445566, 1'b1, 1'b0, 1'b0);

        // patched all-ones image, inputs changed mid-image (R8), input held during drain (R1)
        for (int i = 0; i < N; i++) img[i] = 8'hFF;
        run_image(1'b1, 48'hC0FFEE123456, 1'b1, 1'b1, 1'b1);

        // patched all-zero image with all-ones address (R3, R5)
        for (int i = 0; i < N; i++) img[i] = 8'h00;
        rdy_mode = 0;
        run_image(1'b1, 48'hFFFFFFFFFFFF, 1'b0, 1'b0, 1'b0);

        // disabled after patched image: address field must pass unchanged (R6, R8)
        for (int i = 0; i < N; i++) img[i] = 8'(i);
        run_image(1'b0, 48'hA5A5A5A5A5A5, 1'b0, 1'b1, 1'b0);

        @(negedge clk);
        check(in_ready == 1'b1, "R1 idle after image", in_ready, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule